// File: doc/BRIEF.md
# Cascadable Serial-Latch Column Loader

This block collects one display line for an 80-column segment driver from a one-bit serial stream. The data clock and line-latch clock are strobes that a system clock samples. A falling edge on the data clock captures one bit. Every four captured bits form a nibble, and each completed nibble is steered by a group counter into one of twenty addressed 4-bit holding slots.

A falling edge on the line-latch clock copies all held bits into the output register that feeds the column drivers. The same edge clears the counters so that the next line starts from column 1.

Several loaders can be chained. Each one accepts bits only while its active-low enable is low. After its last column is filled, it stops accepting bits and pulls its active-low carry output low. That carry drives the enable of the next loader, so a single stream fills the whole chain in order. A direction input chooses which serial input is used and whether the first bit lands on the lowest or the highest column.

Top module: `ldr_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `col_data` becomes all zeros and `chain_en_n` becomes 1.
- R2: With `dir_rev`=0, bit k of a line (k=0 first), captured from `din_left`, ends up in `col_data[k]` (column k+1) after the next line latch.
- R3: With `dir_rev`=1, bit k of a line, captured from `din_right`, ends up in `col_data[79-k]` after the next line latch.
- R4: While `load_en_n` is 1, falling edges of `shift_clk` capture nothing: `chain_en_n` stays 1 and the held data is unchanged.
- R5: `chain_en_n` goes to 0 when the 80th bit of a line is captured. Further data-clock edges in the same line do not change the held data.
- R6: `chain_en_n` stays 1 while fewer than 80 bits of the line have been captured.
- R7: `col_data` changes only on a falling edge of `line_clk`. Bits being loaded do not appear on it before then.
- R8: A falling edge of `line_clk` releases `chain_en_n` to 1 and restarts the count. A partial nibble of 1 to 3 bits is discarded, and the next captured bit goes to the first column of the new line.
- R9: The serial input not chosen by `dir_rev` has no effect on the loaded data.
- R10: Raising `load_en_n` in the middle of a line pauses loading. When it goes low again, loading continues at the next column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | Data clock; a bit is captured on its falling edge |
| line_clk | input | 1 | Line-latch clock; its falling edge transfers held data and restarts the count |
| load_en_n | input | 1 | Active-low loading enable (the previous loader's carry) |
| dir_rev | input | 1 | 0: `din_left`, first bit to column 1; 1: `din_right`, first bit to column 80 |
| din_left | input | 1 | Serial data used when `dir_rev` is 0 |
| din_right | input | 1 | Serial data used when `dir_rev` is 1 |
| col_data | output | 80 | Latched line; bit c drives column c+1 |
| chain_en_n | output | 1 | Active-low carry; low once the line is full |

## Verification
The bench targets the boundary between the 79th and 80th bit. A loader whose carry fires one bit early or late would enable its neighbour at the wrong column and shift the whole chained image by one pixel. It sends extra bits after the line is full. A loader that does not stop on its own would then overwrite the first slot.

It latches a line while a partial nibble is pending, and then loads a fresh line. A design that kept the bit count would put the new line's data into the wrong nibble positions. It also pauses loading in the middle of a line, drives the unused serial input with the inverse of the data, and checks both directions against a reversed-column model. Together these show any swapped nibble order, any lost count during the pause, or the wrong input being sampled.

// File: rtl/ldr_pkg.sv
// Package: shared constants and types for the serial-latch column loader.
// Assumes: the column count is a whole number of nibbles.
package ldr_pkg;
    localparam int unsigned LDR_COLS_DEF = 80;
    localparam int unsigned LDR_GRP_W    = 4;

    // Direction of column fill
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } ldr_dir_e;
endpackage

// File: rtl/ldr_fall_det.sv
// Module: detects a falling edge on a slow strobe sampled by clk.
// Assumes: the strobe is already synchronous to clk. The history register
// resets low, so no false edge is produced right after reset.
module ldr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic prev_q;

    // Remember the strobe level from the previous clock
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign fall = prev_q && !sig;
endmodule

// File: rtl/ldr_nibble_packer.sv
// Module: packs accepted serial bits into GRP_W-bit words in arrival order
// (first bit to word bit 0). The word and its valid flag are combinational
// in the cycle that delivers the last bit. clear drops any partial word.
// Assumes: GRP_W is a power of two and at least 2.
module ldr_nibble_packer #(
    parameter int unsigned GRP_W = ldr_pkg::LDR_GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic             bit_in,
    output logic             word_vld,
    output logic [GRP_W-1:0] word
);
    localparam int unsigned CNT_W = $clog2(GRP_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [GRP_W-2:0] part_q;

    assign word_vld = take && (cnt_q == LAST);
    assign word     = {bit_in, part_q};

    // Count bit positions and store the bits of the partial word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            part_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (take) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                part_q[cnt_q] <= bit_in;
                cnt_q         <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/ldr_group_steer.sv
// Module: counts completed words and writes each one into its addressed
// holding slot. In reverse direction, both the slot order and the bit order
// inside the word are mirrored. done is set by the final word and blocks
// nothing by itself: the caller gates further words.
// Assumes: NUM_COLS is a multiple of GRP_W. clear has priority over a write.
module ldr_group_steer #(
    parameter int unsigned NUM_COLS = ldr_pkg::LDR_COLS_DEF,
    parameter int unsigned GRP_W    = ldr_pkg::LDR_GRP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                word_vld,
    input  logic                rev,
    input  logic [GRP_W-1:0]    word,
    output logic [NUM_COLS-1:0] hold,
    output logic                done
);
    localparam int unsigned NUM_GRPS = NUM_COLS / GRP_W;
    localparam int unsigned GRP_CW   = $clog2(NUM_GRPS);
    localparam logic [GRP_CW-1:0] GRP_LAST = GRP_CW'(NUM_GRPS - 1);

    logic [GRP_CW-1:0] grp_q;
    logic [GRP_CW-1:0] slot;
    logic [GRP_W-1:0]  word_rev;
    logic [GRP_W-1:0]  wdata;
    logic [GRP_W-1:0]  slot_q [NUM_GRPS];

    genvar gi;
    generate
        for (gi = 0; gi < GRP_W; gi++) begin : g_rev
            assign word_rev[gi] = word[GRP_W-1-gi];
        end
    endgenerate

    assign slot  = rev ? (GRP_LAST - grp_q) : grp_q;
    assign wdata = rev ? word_rev : word;

    // Advance the group counter and flag the end of the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
            done  <= 1'b0;
        end else if (clear) begin
            grp_q <= '0;
            done  <= 1'b0;
        end else if (word_vld) begin
            if (grp_q == GRP_LAST) done  <= 1'b1;
            else                   grp_q <= grp_q + GRP_CW'(1);
        end
    end

    genvar si;
    generate
        for (si = 0; si < NUM_GRPS; si++) begin : g_slot
            // Load this slot when the decoder selects it
            always_ff @(posedge clk) begin
                if (!rst_n)
                    slot_q[si] <= '0;
                else if (!clear && word_vld && (slot == GRP_CW'(si)))
                    slot_q[si] <= wdata;
            end
            assign hold[si*GRP_W +: GRP_W] = slot_q[si];
        end
    endgenerate
endmodule

// File: rtl/ldr_top.sv
// Module: cascadable serial-latch column loader. Samples the data and
// line-latch strobes with clk, packs and steers bits into holding slots,
// raises an active-low carry when the line is full, and copies the held
// line to col_data on each line-latch falling edge.
// Assumes: strobes are synchronous to clk and each level lasts at least
// one clk period.
module ldr_top #(
    parameter int unsigned NUM_COLS = ldr_pkg::LDR_COLS_DEF,
    parameter int unsigned GRP_W    = ldr_pkg::LDR_GRP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_clk,
    input  logic                line_clk,
    input  logic                load_en_n,
    input  logic                dir_rev,
    input  logic                din_left,
    input  logic                din_right,
    output logic [NUM_COLS-1:0] col_data,
    output logic                chain_en_n
);
    import ldr_pkg::*;

    logic                shift_fall;
    logic                line_fall;
    logic                done;
    logic                take;
    logic                bit_sel;
    logic                word_vld;
    logic [GRP_W-1:0]    word;
    logic [NUM_COLS-1:0] hold;
    ldr_dir_e            dir;

    ldr_fall_det u_shift_det (.clk(clk), .rst_n(rst_n), .sig(shift_clk), .fall(shift_fall));
    ldr_fall_det u_line_det  (.clk(clk), .rst_n(rst_n), .sig(line_clk),  .fall(line_fall));

    assign dir     = ldr_dir_e'(dir_rev);
    assign bit_sel = (dir == DIR_REV) ? din_right : din_left;
    assign take    = shift_fall && !load_en_n && !done;

    ldr_nibble_packer #(.GRP_W(GRP_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(line_fall), .take(take),
        .bit_in(bit_sel), .word_vld(word_vld), .word(word)
    );

    ldr_group_steer #(.NUM_COLS(NUM_COLS), .GRP_W(GRP_W)) u_steer (
        .clk(clk), .rst_n(rst_n), .clear(line_fall), .word_vld(word_vld),
        .rev(dir == DIR_REV), .word(word), .hold(hold), .done(done)
    );

    // Transfer the held line to the driver latch on a line-latch edge
    always_ff @(posedge clk) begin
        if (!rst_n)         col_data <= '0;
        else if (line_fall) col_data <= hold;
    end

    assign chain_en_n = !done;
endmodule

// File: rtl/ldr_top_chk.sv
// Module: property checker for ldr_top, attached by bind. It recomputes the
// strobe edges from the ports on its own.
module ldr_top_chk #(
    parameter int unsigned NUM_COLS = 80
) (
    input logic                clk,
    input logic                rst_n,
    input logic                shift_clk,
    input logic                line_clk,
    input logic                load_en_n,
    input logic [NUM_COLS-1:0] col_data,
    input logic                chain_en_n
);
    logic pl_q, ps_q, lf, sf;

    // Port-level history for the edge checks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_q <= 1'b0;
            ps_q <= 1'b0;
        end else begin
            pl_q <= line_clk;
            ps_q <= shift_clk;
        end
    end
    assign lf = pl_q && !line_clk;
    assign sf = ps_q && !shift_clk;

    p_reset_values_r1: assert property (@(posedge clk)
        !rst_n |=> (col_data == '0 && chain_en_n));

    p_out_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lf |=> $stable(col_data));

    p_carry_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lf |=> chain_en_n);

    p_carry_needs_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chain_en_n) |-> $past(sf && !load_en_n));

    p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en_n && !lf) |=> $stable(chain_en_n));
endmodule

bind ldr_top ldr_top_chk #(.NUM_COLS(NUM_COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_clk(line_clk),
    .load_en_n(load_en_n), .col_data(col_data), .chain_en_n(chain_en_n)
);

// File: tb/tb_ldr_top.sv
`timescale 1ns/1ps
module tb_ldr_top;
    localparam int NC = 80;

    logic          clk = 1'b0;
    logic          rst_n, shift_clk, line_clk, load_en_n, dir_rev, din_left, din_right;
    logic [NC-1:0] col_data;
    logic          chain_en_n;
    int            checks = 0;
    int            fails  = 0;
    logic [NC-1:0] model;

    // bit 80 = direction, bits 79..0 = line, bit k sent k-th
    localparam logic [NC:0] VEC [4] = '{
        {1'b0, 80'h0123_4567_89AB_CDEF_F00D},
        {1'b1, 80'h0123_4567_89AB_CDEF_F00D},
        {1'b0, 80'hFFFF_0000_FFFF_0000_A5A5},
        {1'b1, 80'h8000_0000_0000_0000_0001}
    };
    localparam logic [NC-1:0] PAT_P = 80'hDEAD_BEEF_1234_5678_9ABC;
    localparam logic [NC-1:0] PAT_Q = 80'h5555_AAAA_3333_CCCC_0F0F;
    localparam logic [NC-1:0] PAT_S = 80'h1357_9BDF_2468_ACE0_7E81;

    ldr_top dut (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .line_clk(line_clk),
        .load_en_n(load_en_n), .dir_rev(dir_rev), .din_left(din_left),
        .din_right(din_right), .col_data(col_data), .chain_en_n(chain_en_n)
    );

    always #5 clk = ~clk;

    // Expected hold after the first n bits: only complete nibbles are written
    function automatic logic [NC-1:0] apply(input logic [NC-1:0] base, input logic dir,
                                            input logic [NC-1:0] data, input int lo, input int n);
        logic [NC-1:0] r = base;
        for (int k = lo; k < (n / 4) * 4; k++) begin
            if (dir) r[NC-1-k] = data[k];
            else     r[k]      = data[k];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [NC-1:0] act, input logic [NC-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Unused input always carries the inverse bit (R9)
    task automatic send_bit(input logic b);
        if (dir_rev) begin din_right = b; din_left = ~b; end
        else         begin din_left = b;  din_right = ~b; end
        shift_clk = 1'b0;
        @(negedge clk);
        shift_clk = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_range(input logic [NC-1:0] d, input int lo, input int hi);
        for (int i = lo; i < hi; i++) send_bit(d[i]);
    endtask

    task automatic latch_line();
        line_clk = 1'b0;
        @(negedge clk);
        line_clk = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; shift_clk = 1'b1; line_clk = 1'b1; load_en_n = 1'b1;
        dir_rev = 1'b0; din_left = 1'b0; din_right = 1'b0;
        repeat (3) @(negedge clk);
        chk(col_data == '0, "R1 reset data", col_data, '0);
        chk(chain_en_n == 1'b1, "R1 reset carry", NC'(chain_en_n), NC'(1));
        rst_n = 1'b1;
        @(negedge clk);
        model = '0;

        // Vector table: full lines in both directions
        load_en_n = 1'b0;
        for (int v = 0; v < 4; v++) begin
            dir_rev = VEC[v][NC];
            send_range(VEC[v][NC-1:0], 0, NC);
            chk(chain_en_n == 1'b0, "R5 carry after 80", NC'(chain_en_n), '0);
            latch_line();
            model = apply(model, dir_rev, VEC[v][NC-1:0], 0, NC);
            chk(col_data == model, dir_rev ? "R3+R9 reverse map" : "R2+R9 forward map", col_data, model);
            chk(chain_en_n == 1'b1, "R8 carry released", NC'(chain_en_n), NC'(1));
        end

        // R6: 79 bits keep carry high, the 80th drops it
        dir_rev = 1'b0;
        send_range(PAT_P, 0, NC - 1);
        chk(chain_en_n == 1'b1, "R6 carry at 79", NC'(chain_en_n), NC'(1));
        send_range(PAT_P, NC - 1, NC);
        chk(chain_en_n == 1'b0, "R5 carry at 80", NC'(chain_en_n), '0);
        // R7: loaded bits not visible before the latch
        chk(col_data == model, "R7 output held", col_data, model);
        // R5: extra bits ignored
        send_range(PAT_Q, 0, 8);
        latch_line();
        model = PAT_P;
        chk(col_data == model, "R5 extra bits ignored", col_data, model);

        // R4: disabled loader ignores bits
        load_en_n = 1'b1;
        send_range(PAT_Q, 0, NC);
        chk(chain_en_n == 1'b1, "R4 carry stays high", NC'(chain_en_n), NC'(1));
        latch_line();
        chk(col_data == model, "R4 hold unchanged", col_data, model);

        // R8: partial nibble discarded, next line restarts at column 1
        load_en_n = 1'b0;
        send_range(PAT_Q, 0, 6);
        latch_line();
        model = apply(model, 1'b0, PAT_Q, 0, 6);
        chk(col_data == model, "R8 partial nibble dropped", col_data, model);
        send_range(PAT_S, 0, NC);
        latch_line();
        model = PAT_S;
        chk(col_data == model, "R8 fresh line start", col_data, model);

        // R10: pause mid-line and resume
        send_range(PAT_P, 0, 40);
        load_en_n = 1'b1;
        send_range(PAT_Q, 0, 20);
        chk(chain_en_n == 1'b1, "R10 carry during pause", NC'(chain_en_n), NC'(1));
        load_en_n = 1'b0;
        send_range(PAT_P, 40, NC);
        chk(chain_en_n == 1'b0, "R10 carry after resume", NC'(chain_en_n), '0);
        latch_line();
        model = PAT_P;
        chk(col_data == model, "R10 resumed line", col_data, model);

        // R1: reset in the middle of a line
        send_range(PAT_Q, 0, 20);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(col_data == '0, "R1 mid-line reset data", col_data, '0);
        chk(chain_en_n == 1'b1, "R1 mid-line reset carry", NC'(chain_en_n), NC'(1));
        rst_n = 1'b1;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule